// File: doc/BRIEF.md
# Shift, Rotate and Bit Unit

This block is the single-operand byte manipulator that sits beside the main ALU of a small 8-bit processor core. It serves the extended (prefixed) opcode group. For one selected byte it performs a rotate through carry, a circular rotate, a left shift, an arithmetic or logical right shift, or a nibble exchange. It can also test, clear or set one bit at a chosen index. It is purely combinational. The decoder presents an operation code, a bit index, the operand byte and the current flag nibble. Within the same cycle the unit returns the new byte, a strobe that says whether the byte must be written back, and the new flag nibble.

There is no clock, no state and no state machine. The only "modes" are the operation codes listed below, and each one is decided on every evaluation. Fetching the operand from a register or from memory, and decoding the instruction, belong to the surrounding core.

Flag nibble layout (both `flags_in` and `flags_out`): bit 3 = zero (Z), bit 2 = subtract (N), bit 1 = half-carry (H), bit 0 = carry (C). In the requirements, `x` is `operand`, `c` is `flags_in[0]` and MSB is bit 7.

Top module: `shift_bit_unit`

## Requirements
- R1: Code 0 (rotate left through carry): result = {x[6:0], c}; new C = x[7].
- R2: Code 1 (rotate right through carry): result = {c, x[7:1]}; new C = x[0].
- R3: Code 2 (circular left) gives result = {x[6:0], x[7]} with C = x[7]. Code 3 (circular right) gives result = {x[0], x[7:1]} with C = x[0].
- R4: Code 4 (shift left): result = {x[6:0], 0}; new C = x[7].
- R5: Code 5 (arithmetic right shift): result = {x[7], x[7:1]}, so the sign bit is kept; new C = x[0], never x[7].
- R6: Code 6 (logical right shift): result = {0, x[7:1]}; new C = x[0].
- R7: Code 7 (nibble swap): result = {x[3:0], x[7:4]}; new C = 0.
- R8: For codes 0 to 7, write-back is 1, Z = 1 exactly when the result is 0x00, and N = H = 0. The incoming Z, N and H have no effect.
- R9: Code 8 (bit test) has write-back 0 and result = x. Z = NOT x[bit_idx], N = 0, H = 1, and C is unchanged.
- R10: Code 9 (bit clear) clears only bit bit_idx, has write-back 1 and leaves all four flags unchanged, even when the result is zero.
- R11: Code 10 (bit set) sets only bit bit_idx, has write-back 1 and leaves all four flags unchanged.
- R12: Codes 11 to 15 are inert: write-back 0, result = x, flags unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_sel | input | 4 | Operation code (0 to 10 active, 11 to 15 inert) |
| bit_idx | input | 3 | Bit position for test, clear and set |
| operand | input | 8 | Byte to operate on |
| flags_in | input | 4 | Current flags {Z,N,H,C} |
| result | output | 8 | Resulting byte |
| wr_en | output | 1 | High when the result must be written back |
| flags_out | output | 4 | Updated flags {Z,N,H,C} |

## Verification
The bench builds the unit with its default width of eight bits. The three-bit index then covers every bit position, so the clear and set sweeps reach both bit 0 and bit 7. At this width the nibble swap splits the byte exactly at bit 4. Each shift and rotate is driven with operands whose outgoing bit is 1 and with operands whose outgoing bit is 0. Several of these results are 0x00, which exercises the zero flag. The incoming flags are set to all ones in some vectors to show that they are overridden.

// File: rtl/sbu_pkg.sv
package sbu_pkg;

    typedef enum logic [3:0] {
        OP_RLT = 4'd0,
        OP_RRT = 4'd1,
        OP_ROL = 4'd2,
        OP_ROR = 4'd3,
        OP_SHL = 4'd4,
        OP_ASR = 4'd5,
        OP_LSR = 4'd6,
        OP_SWP = 4'd7,
        OP_TST = 4'd8,
        OP_CLR = 4'd9,
        OP_SET = 4'd10
    } sbu_op_e;

    typedef struct packed {
        logic z;
        logic n;
        logic h;
        logic c;
    } sbu_flags_t;

endpackage

// File: rtl/sbu_shifter.sv
module sbu_shifter
    import sbu_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  sbu_op_e             op,
    input  logic [DATA_W-1:0]   din,
    input  logic                cin,
    output logic [DATA_W-1:0]   dout,
    output logic                cout,
    output logic                hit
);
    localparam int MSB  = DATA_W - 1;
    localparam int HALF = DATA_W / 2;

    always_comb begin
        dout = din;
        cout = cin;
        hit  = 1'b1;
        unique case (op)
            OP_RLT: begin dout = {din[MSB-1:0], cin};      cout = din[MSB]; end
            OP_RRT: begin dout = {cin, din[MSB:1]};        cout = din[0];   end
            OP_ROL: begin dout = {din[MSB-1:0], din[MSB]}; cout = din[MSB]; end
            OP_ROR: begin dout = {din[0], din[MSB:1]};     cout = din[0];   end
            OP_SHL: begin dout = {din[MSB-1:0], 1'b0};     cout = din[MSB]; end
            OP_ASR: begin dout = {din[MSB], din[MSB:1]};   cout = din[0];   end
            OP_LSR: begin dout = {1'b0, din[MSB:1]};       cout = din[0];   end
            OP_SWP: begin dout = {din[HALF-1:0], din[MSB:HALF]}; cout = 1'b0; end
            default: hit = 1'b0;
        endcase
    end
endmodule

// File: rtl/sbu_bitops.sv
module sbu_bitops
    import sbu_pkg::*;
#(
    parameter int DATA_W = 8,
    localparam int IDX_W = $clog2(DATA_W)
) (
    input  sbu_op_e             op,
    input  logic [IDX_W-1:0]    idx,
    input  logic [DATA_W-1:0]   din,
    output logic [DATA_W-1:0]   dout,
    output logic                picked,
    output logic                is_test,
    output logic                is_mod
);
    logic [DATA_W-1:0] sel_mask;

    for (genvar g = 0; g < DATA_W; g++) begin : g_mask
        assign sel_mask[g] = (idx == IDX_W'(g));
    end

    assign picked = |(din & sel_mask);

    always_comb begin
        dout    = din;
        is_test = 1'b0;
        is_mod  = 1'b0;
        unique case (op)
            OP_TST: is_test = 1'b1;
            OP_CLR: begin dout = din & ~sel_mask; is_mod = 1'b1; end
            OP_SET: begin dout = din |  sel_mask; is_mod = 1'b1; end
            default: ;
        endcase
    end
endmodule

// File: rtl/sbu_merge.sv
module sbu_merge
    import sbu_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic [DATA_W-1:0]   din,
    input  sbu_flags_t          fin,
    input  logic                sh_hit,
    input  logic [DATA_W-1:0]   sh_res,
    input  logic                sh_cout,
    input  logic                bt_test,
    input  logic                bt_mod,
    input  logic                bt_pick,
    input  logic [DATA_W-1:0]   bt_res,
    output logic [DATA_W-1:0]   dout,
    output logic                wr,
    output sbu_flags_t          fout
);
    always_comb begin
        dout = din;
        wr   = 1'b0;
        fout = fin;
        if (sh_hit) begin
            dout   = sh_res;
            wr     = 1'b1;
            fout.z = (sh_res == '0);
            fout.n = 1'b0;
            fout.h = 1'b0;
            fout.c = sh_cout;
        end else if (bt_test) begin
            fout.z = ~bt_pick;
            fout.n = 1'b0;
            fout.h = 1'b1;
        end else if (bt_mod) begin
            dout = bt_res;
            wr   = 1'b1;
        end
    end
endmodule

// File: rtl/shift_bit_unit.sv
module shift_bit_unit
    import sbu_pkg::*;
#(
    parameter int DATA_W = 8,
    localparam int IDX_W = $clog2(DATA_W)
) (
    input  logic [3:0]          op_sel,
    input  logic [IDX_W-1:0]    bit_idx,
    input  logic [DATA_W-1:0]   operand,
    input  logic [3:0]          flags_in,
    output logic [DATA_W-1:0]   result,
    output logic                wr_en,
    output logic [3:0]          flags_out
);
    sbu_op_e           op;
    sbu_flags_t        fin, fout;
    logic [DATA_W-1:0] sh_res, bt_res;
    logic              sh_cout, sh_hit, bt_pick, bt_test, bt_mod;

    assign op        = sbu_op_e'(op_sel);
    assign fin       = sbu_flags_t'(flags_in);
    assign flags_out = fout;

    sbu_shifter #(.DATA_W(DATA_W)) u_shift (
        .op(op), .din(operand), .cin(fin.c),
        .dout(sh_res), .cout(sh_cout), .hit(sh_hit)
    );

    sbu_bitops #(.DATA_W(DATA_W)) u_bits (
        .op(op), .idx(bit_idx), .din(operand),
        .dout(bt_res), .picked(bt_pick), .is_test(bt_test), .is_mod(bt_mod)
    );

    sbu_merge #(.DATA_W(DATA_W)) u_merge (
        .din(operand), .fin(fin),
        .sh_hit(sh_hit), .sh_res(sh_res), .sh_cout(sh_cout),
        .bt_test(bt_test), .bt_mod(bt_mod), .bt_pick(bt_pick), .bt_res(bt_res),
        .dout(result), .wr(wr_en), .fout(fout)
    );
endmodule

// File: rtl/sbu_checker.sv
module sbu_checker #(
    parameter int DATA_W = 8,
    localparam int IDX_W = $clog2(DATA_W)
) (
    input logic [3:0]          op_sel,
    input logic [IDX_W-1:0]    bit_idx,
    input logic [DATA_W-1:0]   operand,
    input logic [3:0]          flags_in,
    input logic [DATA_W-1:0]   result,
    input logic                wr_en,
    input logic [3:0]          flags_out
);
    logic [DATA_W-1:0] one_hot;
    logic              known;

    assign one_hot = {{(DATA_W-1){1'b0}}, 1'b1} << bit_idx;
    assign known   = !$isunknown({op_sel, bit_idx, operand, flags_in});

    always_comb begin
        if (known) begin
            // R8
            shift_flags_chk: assert (op_sel > 4'd7 ||
                (wr_en && flags_out[3] == (result == '0) && !flags_out[2] && !flags_out[1]));
            // R5
            asr_sign_chk: assert (op_sel != 4'd5 ||
                (result[DATA_W-1] == operand[DATA_W-1] && flags_out[0] == operand[0]));
            // R7
            swap_carry_chk: assert (op_sel != 4'd7 || !flags_out[0]);
            // R9
            test_nowrite_chk: assert (op_sel != 4'd8 ||
                (!wr_en && result == operand && flags_out[0] == flags_in[0] &&
                 flags_out[1] && !flags_out[2] && flags_out[3] == ((operand & one_hot) == '0)));
            // R10
            clear_one_chk: assert (op_sel != 4'd9 ||
                (wr_en && ((result ^ operand) & ~one_hot) == '0 &&
                 (result & one_hot) == '0 && flags_out == flags_in));
            // R11
            set_one_chk: assert (op_sel != 4'd10 ||
                (wr_en && ((result ^ operand) & ~one_hot) == '0 &&
                 (result & one_hot) != '0 && flags_out == flags_in));
            // R12
            inert_code_chk: assert (op_sel < 4'd11 ||
                (!wr_en && result == operand && flags_out == flags_in));
        end
    end
endmodule

bind shift_bit_unit sbu_checker #(.DATA_W(DATA_W)) u_chk (
    .op_sel(op_sel), .bit_idx(bit_idx), .operand(operand), .flags_in(flags_in),
    .result(result), .wr_en(wr_en), .flags_out(flags_out)
);

// File: tb/shift_bit_unit_test.sv
module shift_bit_unit_test;
    logic       clk = 1'b0;
    logic [3:0] op_sel = '0;
    logic [2:0] bit_idx = '0;
    logic [7:0] operand = '0;
    logic [3:0] flags_in = '0;
    logic [7:0] result;
    logic       wr_en;
    logic [3:0] flags_out;
    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    shift_bit_unit uut (
        .op_sel(op_sel), .bit_idx(bit_idx), .operand(operand), .flags_in(flags_in),
        .result(result), .wr_en(wr_en), .flags_out(flags_out)
    );

    task automatic run(input string tag, input logic [3:0] op, input logic [2:0] idx,
                       input logic [7:0] x, input logic [3:0] fl,
                       input logic [7:0] e_res, input logic e_wr, input logic [3:0] e_fl);
        @(negedge clk);
        op_sel = op; bit_idx = idx; operand = x; flags_in = fl;
        #1;
        n_chk++;
        if (result !== e_res || wr_en !== e_wr || flags_out !== e_fl) begin
            n_bad++;
            $display("FAIL %s op=%0d x=%h: res=%h wr=%b fl=%h expected res=%h wr=%b fl=%h",
                     tag, op, x, result, wr_en, flags_out, e_res, e_wr, e_fl);
        end
    endtask

    task automatic t_idle_state();
        run("R12 initial", 4'd15, 3'd0, 8'h00, 4'h0, 8'h00, 1'b0, 4'h0);
    endtask

    task automatic t_rotate_carry();
        run("R1 R8", 4'd0, 3'd0, 8'h80, 4'h6, 8'h00, 1'b1, 4'h9);
        run("R1",    4'd0, 3'd0, 8'h55, 4'h1, 8'hAB, 1'b1, 4'h0);
        run("R2 R8", 4'd1, 3'd0, 8'h01, 4'h0, 8'h00, 1'b1, 4'h9);
        run("R2",    4'd1, 3'd0, 8'h02, 4'h1, 8'h81, 1'b1, 4'h0);
    endtask

    task automatic t_rotate_circ();
        run("R3 left",  4'd2, 3'd0, 8'h85, 4'h0, 8'h0B, 1'b1, 4'h1);
        run("R3 left0", 4'd2, 3'd0, 8'h00, 4'h7, 8'h00, 1'b1, 4'h8);
        run("R3 right", 4'd3, 3'd0, 8'h01, 4'h0, 8'h80, 1'b1, 4'h1);
        run("R3 right", 4'd3, 3'd0, 8'h80, 4'h1, 8'h40, 1'b1, 4'h0);
    endtask

    task automatic t_shifts();
        run("R4 R8", 4'd4, 3'd0, 8'h80, 4'hF, 8'h00, 1'b1, 4'h9);
        run("R4",    4'd4, 3'd0, 8'h41, 4'h1, 8'h82, 1'b1, 4'h0);
        run("R5",    4'd5, 3'd0, 8'h81, 4'h0, 8'hC0, 1'b1, 4'h1);
        run("R5",    4'd5, 3'd0, 8'h7E, 4'h1, 8'h3F, 1'b1, 4'h0);
        run("R5 R8", 4'd5, 3'd0, 8'h01, 4'h0, 8'h00, 1'b1, 4'h9);
        run("R6",    4'd6, 3'd0, 8'h81, 4'h0, 8'h40, 1'b1, 4'h1);
        run("R6",    4'd6, 3'd0, 8'hFE, 4'hF, 8'h7F, 1'b1, 4'h0);
    endtask

    task automatic t_swap();
        run("R7",    4'd7, 3'd0, 8'hA5, 4'hF, 8'h5A, 1'b1, 4'h0);
        run("R7 R8", 4'd7, 3'd0, 8'h00, 4'h1, 8'h00, 1'b1, 4'h8);
    endtask

    task automatic t_bit_test();
        run("R9 set bit",   4'd8, 3'd4, 8'h10, 4'h1, 8'h10, 1'b0, 4'h3);
        run("R9 clear bit", 4'd8, 3'd3, 8'h10, 4'h1, 8'h10, 1'b0, 4'hB);
        run("R9 msb",       4'd8, 3'd7, 8'h7F, 4'h4, 8'h7F, 1'b0, 4'hA);
    endtask

    task automatic t_bit_modify();
        for (int i = 0; i < 8; i++) begin
            run("R10 sweep", 4'd9,  3'(i), 8'hFF, 4'h5, 8'hFF & ~(8'h01 << i), 1'b1, 4'h5);
            run("R11 sweep", 4'd10, 3'(i), 8'h00, 4'h9, 8'h01 << i, 1'b1, 4'h9);
        end
        run("R10 zero keeps flags", 4'd9,  3'd3, 8'h08, 4'h6, 8'h00, 1'b1, 4'h6);
        run("R11 already set",      4'd10, 3'd2, 8'hFF, 4'h0, 8'hFF, 1'b1, 4'h0);
    endtask

    task automatic t_inert_codes();
        for (int k = 11; k < 16; k++)
            run("R12", 4'(k), 3'd5, 8'h3C, 4'hA, 8'h3C, 1'b0, 4'hA);
    endtask

    initial begin
        t_idle_state();
        t_rotate_carry();
        t_rotate_circ();
        t_shifts();
        t_swap();
        t_bit_test();
        t_bit_modify();
        t_inert_codes();
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog (all requirements): run did not finish, expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule